// File: doc/BRIEF.md
# Tone Band Discriminator

This block decides whether a squared audio tone belongs to the low band (roughly 300 Hz to 660 Hz) or the high band (roughly 900 Hz to 2150 Hz). It counts rising edges of the squared input over a fixed observation window that repeats without gaps. At the end of each window it classifies the count. The default window is 35080 system-clock cycles, about 9.8 ms at 3.579545 MHz. The squared input comes from the zero-crossing detector ahead of it.

The band decision is sticky. A count that lands in the band already held changes nothing. A count in the other band switches the band and raises a one-cycle change pulse, which the downstream frequency measurement uses to drop a count in progress. A count in neither band leaves the band as it was and raises a one-cycle out-of-range pulse. Counts in the gap between the bands fall in this case and are never reported as a valid band.

The classifier is a three-state machine:
- `ST_UNKNOWN` is the state after reset.
- `ST_LOW` holds the low band.
- `ST_HIGH` holds the high band.

It has four named transitions, and each one happens only at a window end:
- `T_ACQ_LOW`: from `ST_UNKNOWN` to `ST_LOW`.
- `T_ACQ_HIGH`: from `ST_UNKNOWN` to `ST_HIGH`.
- `T_TO_HIGH`: from `ST_LOW` to `ST_HIGH`.
- `T_TO_LOW`: from `ST_HIGH` to `ST_LOW`.

In every other case the machine holds its state.

Top module: `tone_band_discriminator`

## Requirements
- R1: While `rst` is high and after it is released, `band_valid`, `band_hi`, `band_change` and `range_err` are 0. `band_valid` stays 0 until the first complete window has produced a count in one of the two bands. Once set, it stays 1 until the next reset.
- R2: A window is exactly `WIN_CYCLES` enabled clock cycles. The count for a window is the number of rising edges of `tone_sq` that it contains. Each edge is seen after a two-flop synchronizer and an edge detector, and only rising edges are counted.
- R3: A window count from `LO_MIN` to `LO_MAX` inclusive (default 3 to 6) selects the low band: `band_valid`=1 and `band_hi`=0.
- R4: A window count from `HI_MIN` to `HI_MAX` inclusive (default 9 to 21) selects the high band: `band_valid`=1 and `band_hi`=1.
- R5: A window count in neither range leaves `band_hi` and `band_valid` unchanged and drives `range_err` high for exactly one cycle after the window end. This covers the gap counts 7 and 8, counts below 3, and counts above 21.
- R6: A count in the band already held keeps that band and raises neither `band_change` nor `range_err`.
- R7: `band_change` is high for exactly one cycle, the cycle after a window end at which the state changed. This includes the first acquisition of a band after reset.
- R8: The edge count saturates at its maximum value, 2^CNT_W-1, where CNT_W is derived from `HI_MAX`. Any number of edges above `HI_MAX` is therefore out of range and never wraps into a band.
- R9: While `enable` is 0, the window position and the edge count are held at zero, the band is kept, and no pulse is produced. Edges seen while disabled are discarded. Raising `enable` starts a fresh full window.
- R10: Asserting `rst` at any time returns the block to the R1 state. After release, the next band needs a full window of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the window and count when 1 |
| tone_sq | input | 1 | Squared audio from the zero-crossing detector, asynchronous |
| band_hi | output | 1 | 1 = high band, 0 = low band (meaningful when `band_valid`) |
| band_valid | output | 1 | A band has been decided since reset |
| band_change | output | 1 | One-cycle pulse when the decided band changes |
| range_err | output | 1 | One-cycle pulse when a window count fits neither band |

## Verification
The bench builds the block with `WIN_CYCLES`=128 and the default thresholds, so CNT_W is 5 and the count saturates at 31. The short window lets the bench place an exact number of pulses inside each window with margin for the synchronizer delay. This brings every threshold edge within reach in a few hundred cycles: counts 2, 3, 6, 7, 8, 9, 21 and 22. A 40-pulse window drives the counter into saturation. The bench also covers disabled spans with edge activity that must be discarded, and a reset in the middle of operation followed by fresh acquisition.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

    typedef enum logic [1:0] {
        ST_UNKNOWN = 2'd0,
        ST_LOW     = 2'd1,
        ST_HIGH    = 2'd2
    } band_state_t;

    typedef enum logic [1:0] {
        CLS_LOW  = 2'd0,
        CLS_HIGH = 2'd1,
        CLS_NONE = 2'd2
    } count_class_t;

endpackage

// File: rtl/tbd_edge_sync.sv
module tbd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_i;
    end

    for (genvar g = 1; g < CHAIN; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b0;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    // A single rising edge yields one pulse of one cycle
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tbd_window.sv
module tbd_window #(
    parameter int WIN_CYCLES = 35080
) (
    input  logic clk,
    input  logic rst,
    input  logic enable_i,
    output logic win_end_o
);
    localparam int WW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WW-1:0] LAST = WW'(WIN_CYCLES - 1);

    logic [WW-1:0] pos_q;

    assign win_end_o = enable_i && (pos_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !enable_i) pos_q <= '0;
        else if (win_end_o)   pos_q <= '0;
        else                  pos_q <= pos_q + WW'(1);
    end

    assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (pos_q == '0));

    assert_window_gap_R2: assert property (@(posedge clk) disable iff (rst)
        win_end_o |=> !win_end_o);

endmodule

// File: rtl/tbd_cycle_counter.sv
module tbd_cycle_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             rise_i,
    input  logic             win_end_i,
    output logic [CNT_W-1:0] tally_o
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             bump;

    assign bump    = rise_i && (cnt_q != CMAX);
    assign tally_o = bump ? cnt_q + CNT_W'(1) : cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !enable_i) cnt_q <= '0;
        else if (win_end_i)   cnt_q <= '0;
        else if (bump)        cnt_q <= cnt_q + CNT_W'(1);
    end

    assert_saturate_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CMAX) && enable_i && !win_end_i |=> (cnt_q == CMAX));

    assert_discard_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (cnt_q == '0));

endmodule

// File: rtl/tbd_classifier.sv
module tbd_classifier
    import tbd_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int LO_MIN = 3,
    parameter int LO_MAX = 6,
    parameter int HI_MIN = 9,
    parameter int HI_MAX = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             win_end_i,
    input  logic [CNT_W-1:0] tally_i,
    output logic             band_hi_o,
    output logic             band_valid_o,
    output logic             band_change_o,
    output logic             range_err_o
);
    localparam logic [CNT_W-1:0] LO_MIN_C = CNT_W'(LO_MIN);
    localparam logic [CNT_W-1:0] LO_MAX_C = CNT_W'(LO_MAX);
    localparam logic [CNT_W-1:0] HI_MIN_C = CNT_W'(HI_MIN);
    localparam logic [CNT_W-1:0] HI_MAX_C = CNT_W'(HI_MAX);

    band_state_t  state_q, state_d;
    count_class_t cls;

    always_comb begin
        if (tally_i >= LO_MIN_C && tally_i <= LO_MAX_C)      cls = CLS_LOW;
        else if (tally_i >= HI_MIN_C && tally_i <= HI_MAX_C) cls = CLS_HIGH;
        else                                                 cls = CLS_NONE;
    end

    // Next-state logic; transitions only at a window end
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNKNOWN: begin
                if (win_end_i && cls == CLS_LOW)  state_d = ST_LOW;   // T_ACQ_LOW
                if (win_end_i && cls == CLS_HIGH) state_d = ST_HIGH;  // T_ACQ_HIGH
            end
            ST_LOW: begin
                if (win_end_i && cls == CLS_HIGH) state_d = ST_HIGH;  // T_TO_HIGH
            end
            ST_HIGH: begin
                if (win_end_i && cls == CLS_LOW)  state_d = ST_LOW;   // T_TO_LOW
            end
            default: state_d = ST_UNKNOWN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_UNKNOWN;
        else     state_q <= state_d;
    end

    // Registered pulse outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            band_change_o <= 1'b0;
            range_err_o   <= 1'b0;
        end else begin
            band_change_o <= (state_d != state_q);
            range_err_o   <= win_end_i && (cls == CLS_NONE);
        end
    end

    assign band_hi_o    = (state_q == ST_HIGH);
    assign band_valid_o = (state_q != ST_UNKNOWN);

    assert_valid_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        band_valid_o |=> band_valid_o);

    assert_err_at_window_R5: assert property (@(posedge clk) disable iff (rst)
        range_err_o |-> $past(win_end_i));

    assert_hold_on_none_R5: assert property (@(posedge clk) disable iff (rst)
        win_end_i && (cls == CLS_NONE) |=> $stable(band_hi_o) && $stable(band_valid_o));

    assert_same_band_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        win_end_i && ((cls == CLS_HIGH && band_hi_o && band_valid_o) ||
                      (cls == CLS_LOW && !band_hi_o && band_valid_o)) |=> !band_change_o);

    assert_change_marked_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(band_hi_o) |-> band_change_o);

    assert_change_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        band_change_o |-> $past(win_end_i));

endmodule

// File: rtl/tone_band_discriminator.sv
module tone_band_discriminator #(
    parameter int WIN_CYCLES  = 35080,
    parameter int LO_MIN      = 3,
    parameter int LO_MAX      = 6,
    parameter int HI_MIN      = 9,
    parameter int HI_MAX      = 21,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic tone_sq,
    output logic band_hi,
    output logic band_valid,
    output logic band_change,
    output logic range_err
);
    localparam int CNT_W = $clog2(HI_MAX + 2);

    logic             rise;
    logic             win_end;
    logic [CNT_W-1:0] tally;

    tbd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (tone_sq),
        .rise_o  (rise)
    );

    tbd_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
        .clk       (clk),
        .rst       (rst),
        .enable_i  (enable),
        .win_end_o (win_end)
    );

    tbd_cycle_counter #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .enable_i  (enable),
        .rise_i    (rise),
        .win_end_i (win_end),
        .tally_o   (tally)
    );

    tbd_classifier #(
        .CNT_W  (CNT_W),
        .LO_MIN (LO_MIN),
        .LO_MAX (LO_MAX),
        .HI_MIN (HI_MIN),
        .HI_MAX (HI_MAX)
    ) u_cls (
        .clk           (clk),
        .rst           (rst),
        .win_end_i     (win_end),
        .tally_i       (tally),
        .band_hi_o     (band_hi),
        .band_valid_o  (band_valid),
        .band_change_o (band_change),
        .range_err_o   (range_err)
    );

    assert_quiet_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !band_change && !range_err);

endmodule

// File: tb/test_tone_band_discriminator.sv
module test_tone_band_discriminator;
    localparam int WIN = 128;
    localparam int NROWS = 15;

    typedef struct packed {
        logic [7:0] pulses;
        logic       hi;
        logic       valid;
        logic       chg;
        logic       err;
    } vec_t;

    // Windows walked in order from reset
    localparam vec_t VECS [NROWS] = '{
        '{8'd0,  1'b0, 1'b0, 1'b0, 1'b1},  // silence: nothing decided
        '{8'd4,  1'b0, 1'b1, 1'b1, 1'b0},  // acquire low
        '{8'd3,  1'b0, 1'b1, 1'b0, 1'b0},  // low lower edge
        '{8'd6,  1'b0, 1'b1, 1'b0, 1'b0},  // low upper edge
        '{8'd7,  1'b0, 1'b1, 1'b0, 1'b1},  // gap
        '{8'd8,  1'b0, 1'b1, 1'b0, 1'b1},  // gap
        '{8'd2,  1'b0, 1'b1, 1'b0, 1'b1},  // below low
        '{8'd9,  1'b1, 1'b1, 1'b1, 1'b0},  // to high, lower edge
        '{8'd21, 1'b1, 1'b1, 1'b0, 1'b0},  // high upper edge
        '{8'd5,  1'b0, 1'b1, 1'b1, 1'b0},  // to low
        '{8'd15, 1'b1, 1'b1, 1'b1, 1'b0},  // to high
        '{8'd22, 1'b1, 1'b1, 1'b0, 1'b1},  // above high
        '{8'd40, 1'b1, 1'b1, 1'b0, 1'b1},  // saturating count
        '{8'd0,  1'b1, 1'b1, 1'b0, 1'b1},  // silence keeps band
        '{8'd6,  1'b0, 1'b1, 1'b1, 1'b0}   // to low
    };

    logic clk = 1'b0;
    logic rst, enable, tone_sq;
    logic band_hi, band_valid, band_change, range_err;
    int   n_checks = 0;
    int   n_fail   = 0;

    always #4 clk = ~clk;

    tone_band_discriminator #(.WIN_CYCLES(WIN)) i_tone_band_discriminator (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .tone_sq     (tone_sq),
        .band_hi     (band_hi),
        .band_valid  (band_valid),
        .band_change (band_change),
        .range_err   (range_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string row_tag(input int r);
        case (r)
            0:          return "R1";
            1, 2, 3:    return "R3";
            4, 5, 6:    return "R5";
            7, 10:      return "R4";
            8:          return "R6";
            9, 14:      return "R7";
            11:         return "R5";
            12:         return "R8";
            default:    return "R2";
        endcase
    endfunction

    // One window: pulses one cycle wide, two cycles apart, from offset 4
    task automatic run_window(input int n);
        for (int k = 0; k < WIN; k++) begin
            tone_sq = (k >= 4) && (k < 4 + 2 * n) && (((k - 4) % 2) == 0);
            @(posedge clk);
            @(negedge clk);
        end
        tone_sq = 1'b0;
    endtask

    task automatic check_outputs(input string req, input int hi, input int valid,
                                 input int chg, input int err);
        check(req, "band_hi",     int'(band_hi),     hi);
        check(req, "band_valid",  int'(band_valid),  valid);
        check(req, "band_change", int'(band_change), chg);
        check(req, "range_err",   int'(range_err),   err);
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; enable = 1'b1; tone_sq = 1'b0;
        repeat (4) @(negedge clk);
        check_outputs("R1", 0, 0, 0, 0);
        rst = 1'b0;

        // Table walk, R2 through R8
        for (int r = 0; r < NROWS; r++) begin
            run_window(int'(VECS[r].pulses));
            check_outputs(row_tag(r), int'(VECS[r].hi), int'(VECS[r].valid),
                          int'(VECS[r].chg), int'(VECS[r].err));
        end

        // R9: disabled span with edge activity; no pulses, band kept
        begin
            int bad_pulse = 0;
            int bad_band  = 0;
            enable = 1'b0;
            for (int k = 0; k < 60; k++) begin
                tone_sq = (k < 50) && ((k % 2) == 0);
                @(posedge clk);
                @(negedge clk);
                if (band_change || range_err) bad_pulse++;
                if (band_hi || !band_valid)   bad_band++;
            end
            check("R9", "pulses while disabled", bad_pulse, 0);
            check("R9", "band moved while disabled", bad_band, 0);
            enable = 1'b1;
        end
        run_window(4);
        check_outputs("R9", 0, 1, 0, 0);   // disabled edges were discarded
        run_window(12);
        check_outputs("R4", 1, 1, 1, 0);

        // R10: reset during operation
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check_outputs("R10", 0, 0, 0, 0);
        rst = 1'b0;
        run_window(10);
        check_outputs("R10", 1, 1, 1, 0);
        @(posedge clk);
        @(negedge clk);
        check("R7", "change pulse width", int'(band_change), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule